// File: doc/BRIEF.md
# Write-Back Second-Level Cache Controller

This block is the second cache level behind a write-through first-level cache. It takes one request at a time on its upstream side, either a read or a write-through. It looks the address up in a direct-mapped array of tags and line status, then answers with a one-cycle reply that says whether the access hit. The array holds only tags, a valid bit and a modified bit for each line; no data words are stored.

On a miss the controller allocates the line for reads and for writes alike. If the chosen line is valid and modified, it first issues a write-back of that victim line to memory. Only after the write-back finishes does it fetch the requested line. The downstream memory is a responder with latency only. When a memory operation completes, the responder shows its kind and its line address on an observation port, so the order of downstream traffic can be checked. The line count, the lookup latency and the memory latency are parameters.

Top module: `l2wb_cache`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `mem_op_valid` are 0, and every line is invalid, so the first access to any line misses.
- R2: Lines hold four words. The line index is `req_addr[IDXW+1:2]` and the tag is the bits above the index. With 16 lines and 10-bit addresses, word 34 uses line 8 and word 64 uses line 0.
- R3: On a hit, `resp_valid` rises with `resp_hit`=1 exactly HIT_LAT rising edges after the accepting edge, and no memory operation is issued.
- R4: A write that hits marks the line modified, so a later miss that displaces the line writes it back.
- R5: On a miss to an invalid line or a clean line, exactly one memory operation is issued. It has kind read (`mem_op_kind`=2'b01) and the line-aligned address (word offset 0) of the requested line. `resp_valid` rises with `resp_hit`=0 HIT_LAT+MEM_LAT+2 edges after acceptance.
- R6: On a miss to a valid modified line, a write-back (`mem_op_kind`=2'b11) at the victim's line address (old tag, same index, offset 0) completes first. A read of the new line follows it. The reply comes HIT_LAT+2*MEM_LAT+4 edges after acceptance.
- R7: A write miss allocates the line as valid and modified. A later access with the same tag hits, and a later conflicting miss writes the line back.
- R8: A line filled by a read is clean. Displacing it without an intervening write issues no write-back.
- R9: The reply is raised only after every memory operation of the access has completed. No memory operation is in flight or completes in the reply cycle.
- R10: `req_ready` is 0 from the accepting edge until the reply. `resp_valid` is a one-cycle pulse, after which `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream request present |
| req_write | input | 1 | 1 = write-through, 0 = read |
| req_addr | input | AW | Word address of the request |
| req_ready | output | 1 | Controller idle, request accepted at this edge |
| resp_valid | output | 1 | One-cycle reply pulse |
| resp_hit | output | 1 | Reply outcome, 1 = hit |
| mem_op_valid | output | 1 | A memory operation completed this cycle |
| mem_op_kind | output | 2 | Kind of the completed operation: 01 read, 11 write-back |
| mem_op_addr | output | AW | Line-aligned address of the completed operation |

## Verification
The controller is driven first with a short directed trace. In that trace, reads and writes fill lines, write to resident lines, hit again at another offset of the same line, and evict a modified line through index aliasing. This separates write-back-then-fill from a plain fill, and checks the index and tag split at known addresses. Directed pairs then tell a write-allocated line from a read-filled one, by whether a later conflicting miss writes the line back. A long arithmetic address sweep follows over four tags per index. It mixes hits, clean misses and dirty misses in every order. For each access the bench checks the reply latency, the hit flag, and the kind, address and count of the memory operations against a model of the tags and status bits.

// File: rtl/l2wb_pkg.sv
package l2wb_pkg;

  typedef enum logic [1:0] {
    MK_NONE  = 2'b00,
    MK_READ  = 2'b01,
    MK_WRITE = 2'b10,
    MK_WBACK = 2'b11
  } mem_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_RESPOND
  } ctl_state_t;

endpackage

// File: rtl/l2wb_tagstore.sv
module l2wb_tagstore #(
  parameter int LINES = 16,
  parameter int TAGW  = 4,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_idx,
  output logic [TAGW-1:0] rd_tag,
  output logic            rd_valid,
  output logic            rd_dirty,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [TAGW-1:0] wr_tag,
  input  logic            wr_dirty
);

  // Tag array: no reset, synchronous write and read, suitable for block RAM.
  logic [TAGW-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end

  // Status bits live in flops so reset can clear them in one cycle.
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDXW'(g))) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_dirty <= 1'b0;
    end else if (rd_en) begin
      rd_valid <= valid_q[rd_idx];
      rd_dirty <= dirty_q[rd_idx];
    end
  end

endmodule

// File: rtl/l2wb_memresp.sv
module l2wb_memresp #(
  parameter int AW      = 10,
  parameter int MEM_LAT = 4,
  localparam int RW     = $clog2(MEM_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    start_kind,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          done,
  output logic [1:0]    done_kind,
  output logic [AW-1:0] done_addr
);

  logic [RW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      remain    <= '0;
      done_kind <= 2'b00;
      done_addr <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy      <= 1'b1;
        remain    <= RW'(MEM_LAT);
        done_kind <= start_kind;
        done_addr <= start_addr;
      end else if (busy) begin
        if (remain == RW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          remain <= remain - RW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/l2wb_ctrl.sv
module l2wb_ctrl
  import l2wb_pkg::*;
#(
  parameter int AW      = 10,
  parameter int LINES   = 16,
  parameter int HIT_LAT = 2,
  localparam int OFFW   = 2,
  localparam int IDXW   = $clog2(LINES),
  localparam int TAGW   = AW - IDXW - OFFW,
  localparam int CW     = $clog2(HIT_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  output logic            req_ready,
  output logic            resp_valid,
  output logic            resp_hit,
  output logic            ts_rd_en,
  output logic [IDXW-1:0] ts_rd_idx,
  input  logic [TAGW-1:0] ts_rd_tag,
  input  logic            ts_rd_valid,
  input  logic            ts_rd_dirty,
  output logic            ts_wr_en,
  output logic [IDXW-1:0] ts_wr_idx,
  output logic [TAGW-1:0] ts_wr_tag,
  output logic            ts_wr_dirty,
  output logic            mem_start,
  output logic [1:0]      mem_kind,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_done
);

  ctl_state_t    state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] q_addr;
  logic          q_write;

  logic [IDXW-1:0] q_idx;
  logic [TAGW-1:0] q_tag;
  logic            last_lookup;
  logic            hit;

  assign q_idx       = q_addr[OFFW +: IDXW];
  assign q_tag       = q_addr[AW-1 -: TAGW];
  assign last_lookup = (state == ST_LOOKUP) && (cnt == CW'(HIT_LAT - 1));
  assign hit         = ts_rd_valid && (ts_rd_tag == q_tag);

  assign req_ready = (state == ST_IDLE);
  assign ts_rd_en  = (state == ST_IDLE) && req_valid;
  assign ts_rd_idx = req_addr[OFFW +: IDXW];

  // Status update: write hit sets modified; fill sets valid, modified = write.
  assign ts_wr_en    = (last_lookup && hit && q_write) ||
                       ((state == ST_FILL) && mem_done);
  assign ts_wr_idx   = q_idx;
  assign ts_wr_tag   = q_tag;
  assign ts_wr_dirty = q_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      q_addr     <= '0;
      q_write    <= 1'b0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      mem_start  <= 1'b0;
      mem_kind   <= MK_NONE;
      mem_addr   <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_start  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            q_addr  <= req_addr;
            q_write <= req_write;
            cnt     <= '0;
            state   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (last_lookup) begin
            if (hit) begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b1;
              state      <= ST_RESPOND;
            end else if (ts_rd_valid && ts_rd_dirty) begin
              mem_start <= 1'b1;
              mem_kind  <= MK_WBACK;
              mem_addr  <= {ts_rd_tag, q_idx, {OFFW{1'b0}}};
              state     <= ST_WBACK;
            end else begin
              mem_start <= 1'b1;
              mem_kind  <= MK_READ;
              mem_addr  <= {q_tag, q_idx, {OFFW{1'b0}}};
              state     <= ST_FILL;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_WBACK: begin
          if (mem_done) begin
            mem_start <= 1'b1;
            mem_kind  <= MK_READ;
            mem_addr  <= {q_tag, q_idx, {OFFW{1'b0}}};
            state     <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_done) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            state      <= ST_RESPOND;
          end
        end
        ST_RESPOND: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/l2wb_cache.sv
module l2wb_cache #(
  parameter int AW      = 10,
  parameter int LINES   = 16,
  parameter int HIT_LAT = 2,
  parameter int MEM_LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          resp_valid,
  output logic          resp_hit,
  output logic          mem_op_valid,
  output logic [1:0]    mem_op_kind,
  output logic [AW-1:0] mem_op_addr
);

  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW - 2;

  logic            ts_rd_en, ts_rd_valid, ts_rd_dirty;
  logic [IDXW-1:0] ts_rd_idx, ts_wr_idx;
  logic [TAGW-1:0] ts_rd_tag, ts_wr_tag;
  logic            ts_wr_en, ts_wr_dirty;
  logic            mem_start, mem_busy, mem_done;
  logic [1:0]      mem_kind;
  logic [AW-1:0]   mem_addr;

  l2wb_ctrl #(.AW(AW), .LINES(LINES), .HIT_LAT(HIT_LAT)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .ts_rd_en(ts_rd_en), .ts_rd_idx(ts_rd_idx), .ts_rd_tag(ts_rd_tag),
    .ts_rd_valid(ts_rd_valid), .ts_rd_dirty(ts_rd_dirty),
    .ts_wr_en(ts_wr_en), .ts_wr_idx(ts_wr_idx), .ts_wr_tag(ts_wr_tag),
    .ts_wr_dirty(ts_wr_dirty),
    .mem_start(mem_start), .mem_kind(mem_kind), .mem_addr(mem_addr),
    .mem_done(mem_done)
  );

  l2wb_tagstore #(.LINES(LINES), .TAGW(TAGW)) u_tags (
    .clk(clk), .rst(rst),
    .rd_en(ts_rd_en), .rd_idx(ts_rd_idx), .rd_tag(ts_rd_tag),
    .rd_valid(ts_rd_valid), .rd_dirty(ts_rd_dirty),
    .wr_en(ts_wr_en), .wr_idx(ts_wr_idx), .wr_tag(ts_wr_tag),
    .wr_dirty(ts_wr_dirty)
  );

  l2wb_memresp #(.AW(AW), .MEM_LAT(MEM_LAT)) u_mem (
    .clk(clk), .rst(rst),
    .start(mem_start), .start_kind(mem_kind), .start_addr(mem_addr),
    .busy(mem_busy), .done(mem_done),
    .done_kind(mem_op_kind), .done_addr(mem_op_addr)
  );

  assign mem_op_valid = mem_done;

endmodule

// File: rtl/l2wb_checker.sv
module l2wb_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       resp_valid,
  input logic       resp_hit,
  input logic       mem_op_valid,
  input logic [1:0] mem_op_kind,
  input logic       mem_busy
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (req_ready && !resp_valid && !mem_op_valid));

  assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> (!mem_busy && !mem_op_valid));

  assert_op_kind_R5: assert property (@(posedge clk) disable iff (rst)
    mem_op_valid |-> (mem_op_kind == 2'b01 || mem_op_kind == 2'b11));

  assert_mem_done_before_reply_R9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (!mem_busy && !mem_op_valid));

  assert_reply_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> (!resp_valid && req_ready));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_busy || mem_op_valid || resp_valid) |-> !req_ready);

endmodule

bind l2wb_cache l2wb_checker u_l2wb_checker (
  .clk(clk), .rst(rst), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_hit(resp_hit), .mem_op_valid(mem_op_valid), .mem_op_kind(mem_op_kind),
  .mem_busy(mem_busy)
);

// File: tb/test_l2wb_cache.sv
module test_l2wb_cache;

  localparam int AW = 10;
  localparam int LINES = 16;
  localparam int HL = 2;
  localparam int ML = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, resp_valid, resp_hit, mem_op_valid;
  logic [1:0] mem_op_kind;
  logic [AW-1:0] mem_op_addr;

  int checks = 0, failures = 0, cycles = 0;
  bit mv [LINES];
  bit md [LINES];
  logic [3:0] mt [LINES];

  always #2.5 clk = ~clk;

  l2wb_cache #(.AW(AW), .LINES(LINES), .HIT_LAT(HL), .MEM_LAT(ML)) i_l2wb_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .mem_op_valid(mem_op_valid), .mem_op_kind(mem_op_kind),
    .mem_op_addr(mem_op_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_access(input logic [AW-1:0] a, input bit w, input string lbl);
    int idx = int'(a[5:2]);
    logic [3:0] tg = a[9:6];
    bit hit = mv[idx] && (mt[idx] == tg);
    bit dv = !hit && mv[idx] && md[idx];
    int exp_ops = hit ? 0 : (dv ? 2 : 1);
    int exp_lat = hit ? HL : (dv ? HL + 2*ML + 4 : HL + ML + 2);
    string ct = hit ? "R3" : (dv ? "R6" : (w ? "R7" : "R5"));
    string tagtxt = {lbl, " ", ct};
    int n = 0, nops = 0;
    bit got = 0, ready_bad = 0, overlap = 0;
    logic [1:0] k [4];
    logic [AW-1:0] ad [4];
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (mem_op_valid) begin
        if (nops < 4) begin k[nops] = mem_op_kind; ad[nops] = mem_op_addr; end
        nops++;
      end
      if (resp_valid) begin
        got = 1;
        if (mem_op_valid) overlap = 1;
      end else if (req_ready) ready_bad = 1;
    end
    check(n == exp_lat, {tagtxt, " latency"}, n, exp_lat);
    check(resp_hit == hit, {tagtxt, " hit flag"}, int'(resp_hit), int'(hit));
    check(nops == exp_ops, {tagtxt, " R9 mem op count"}, nops, exp_ops);
    check(!overlap, {tagtxt, " R9 op in reply cycle"}, int'(overlap), 0);
    check(!ready_bad, {tagtxt, " R10 ready while busy"}, int'(ready_bad), 0);
    if (nops == exp_ops && dv) begin
      check(k[0] == 2'b11, {tagtxt, " R6 first kind wback"}, int'(k[0]), 3);
      check(ad[0] == {mt[idx], a[5:2], 2'b00}, {tagtxt, " R6 victim addr"},
            int'(ad[0]), int'({mt[idx], a[5:2], 2'b00}));
      check(k[1] == 2'b01, {tagtxt, " R6 second kind read"}, int'(k[1]), 1);
      check(ad[1] == {a[9:2], 2'b00}, {tagtxt, " R6 fill addr"},
            int'(ad[1]), int'({a[9:2], 2'b00}));
    end else if (nops == exp_ops && exp_ops == 1) begin
      check(k[0] == 2'b01, {tagtxt, " R5 kind read"}, int'(k[0]), 1);
      check(ad[0] == {a[9:2], 2'b00}, {tagtxt, " R5 fill addr"},
            int'(ad[0]), int'({a[9:2], 2'b00}));
    end
    @(negedge clk);
    check(!resp_valid && req_ready, {tagtxt, " R10 pulse then ready"},
          int'({resp_valid, req_ready}), 1);
    if (hit) begin
      if (w) md[idx] = 1'b1;
    end else begin
      mv[idx] = 1'b1; mt[idx] = tg; md[idx] = w;
    end
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(req_ready && !resp_valid && !mem_op_valid, "R1 reset state",
          int'({req_ready, resp_valid, mem_op_valid}), 4);

    // Directed trace (R1 first accesses miss, R2 aliasing at 34 and 64)
    do_access(10'd0,  0, "R1");
    do_access(10'd5,  0, "R1");
    do_access(10'd2,  1, "R4");
    do_access(10'd10, 0, "R5");
    do_access(10'd3,  1, "R4");
    do_access(10'd34, 0, "R2");
    do_access(10'd35, 0, "R2");
    do_access(10'd36, 1, "R7");
    do_access(10'd64, 0, "R2");

    // R7: write miss allocates dirty; same-tag read hits, conflict writes back
    do_access(10'd200, 1, "R7");
    do_access(10'd201, 0, "R7");
    do_access(10'd200 + 10'd64, 0, "R7");
    // R8: read-filled line evicted with no write-back
    do_access(10'd12, 0, "R8");
    do_access(10'd12 + 10'd128, 0, "R8");
    // R4: write hit on clean line then conflicting miss
    do_access(10'd13 + 10'd128, 1, "R4");
    do_access(10'd12 + 10'd256, 0, "R4");

    // Arithmetic sweep over four tags per index
    begin
      int s = 7;
      for (int i = 0; i < 600; i++) begin
        logic [AW-1:0] a;
        s = (s * 1103 + 12345) % 65521;
        a = {2'b00, 2'(s >> 3), 4'(s >> 6), 2'(s)};
        do_access(a, bit'((s >> 11) & 1), "sweep");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule